// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Error Checker

This block watches an E1 receive stream that an upstream framer has already aligned to both the basic frame and the 16-frame CRC multiframe. For every timeslot-0 octet it is given two bits: the first bit of the octet and the seventh bit. It also receives the frame's position within the multiframe (0 to 15) and, at the close of each 8-frame sub-multiframe, the CRC-4 remainder that the local CRC datapath computed over that sub-multiframe. From these inputs it produces single-cycle error events:

- a multiframe alignment word mismatch;
- a CRC-4 mismatch;
- an excessive CRC-4 error rate within a one-second window;
- a far-end block error, taken from the E bits;
- two network-terminal indications, decoded from the four Sa6 bits of each sub-multiframe.

A performance monitor or an alarm block is expected to consume these pulses. When the in-multiframe-sync flag is low, every check stops. Stored CRC history and the error count are discarded. After sync returns, only a sub-multiframe or multiframe that was seen from its first frame can raise an event.

Top module: `e1crc_mf_checker`

## Requirements
- R1: Bit 1 of timeslot 0 (port `ts0_bit1_i`) in odd frames 1, 3, 5, 7, 9, 11 forms a 6-bit alignment word, with frame 1 as the MSB. If that word differs from 001011, `mfas_err_o` pulses once, in the cycle after frame 11 is accepted. This happens only if frame 0 of the same multiframe was accepted while in sync.
- R2: In each sub-multiframe (frames 0-7 or 8-15), bit 1 of the even frames carries the received CRC word. The frame at offset 0 is the MSB and the frame at offset 6 is the LSB. `crc_local_i` is sampled together with the last frame (offset 7) of the sub-multiframe it covers, bit 3 aligned with the offset-0 bit. `crc_err_o` pulses in the cycle after offset 6 is accepted when the received word differs from the local CRC stored for the previous sub-multiframe.
- R3: `crc_exc_o` pulses together with the `crc_err_o` pulse that brings the window's CRC error count to exactly EXC_THRESH (default 915). It pulses at most once per window.
- R4: A `sec_tick_i` pulse starts a new window and clears the count. A CRC error in the same cycle as the tick counts as the first error of the new window.
- R5: The E bits are bit 1 of frames 13 and 15. `febe_o` pulses in the cycle after frame 15 is accepted if either E bit is 0.
- R6: Bit 7 of timeslot 0 (port `ts0_bit7_i`) in the odd frames of a sub-multiframe forms a 4-bit Sa6 word, with the frame at offset 1 as the MSB. `nt_febe_o` pulses in the cycle after offset 7 is accepted if the word is 0001 or 0011.
- R7: `nt_crc_o` pulses in the cycle after offset 7 is accepted if the Sa6 word is 0010 or 0011. This is independent of `nt_febe_o`, so both pulse for 0011.
- R8: While `mf_sync_i` is low, no event is produced, the stored local CRC is dropped and the window count is cleared. After sync returns, a sub-multiframe or multiframe whose first frame was not accepted in sync produces no event.
- R9: Synchronous active-high reset clears all outputs to 0. Cycles with `ts0_valid_i` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts0_valid_i | input | 1 | Timeslot-0 bits and frame number are valid this cycle |
| ts0_bit1_i | input | 1 | Bit 1 (first transmitted) of timeslot 0 |
| ts0_bit7_i | input | 1 | Bit 7 of timeslot 0 (Sa6) |
| frame_i | input | 4 | Frame number within the 16-frame multiframe |
| crc_local_i | input | 4 | Local CRC-4 of the sub-multiframe ending with this frame |
| sec_tick_i | input | 1 | One-second window boundary pulse |
| mf_sync_i | input | 1 | In CRC multiframe sync |
| mfas_err_o | output | 1 | Multiframe alignment word error pulse |
| crc_err_o | output | 1 | CRC-4 error pulse |
| crc_exc_o | output | 1 | Excessive CRC-4 error pulse |
| febe_o | output | 1 | Far-end block error pulse |
| nt_febe_o | output | 1 | Network-terminal far-end block error pulse |
| nt_crc_o | output | 1 | Network-terminal CRC error pulse |

## Verification
All 64 alignment words, all 256 pairs of stored and received CRC words, every E-bit pair and all 16 Sa6 codewords are swept. A swapped bit order or a wrong reference word therefore shows up as a pulse on the wrong pattern. The window is driven to exactly 914 errors, then across the threshold and past it, and a tick is placed in the same cycle as an error. An off-by-one threshold, a repeated excessive pulse, or a tick that drops a simultaneous error moves or duplicates `crc_exc_o`. Sync is dropped while corrupt data streams in, then restored in the middle of a multiframe. A design that keeps stale CRC history or judges partially seen words emits pulses where none are expected.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;
  localparam int FRAMES_PER_MF = 16;
  localparam int FRAME_W       = $clog2(FRAMES_PER_MF);
  localparam int SMF_FRAMES    = FRAMES_PER_MF / 2;
  localparam int SMF_W         = $clog2(SMF_FRAMES);
  localparam int CRC_W         = 4;
  localparam int SA6_W         = 4;
  localparam int MFAS_W        = 6;
  localparam int EBIT_W        = 2;

  // frame positions (within a multiframe or a sub-multiframe)
  localparam logic [FRAME_W-1:0] MFAS_LAST_FR = FRAME_W'(11);
  localparam logic [FRAME_W-1:0] EBIT_1ST_FR  = FRAME_W'(13);
  localparam logic [FRAME_W-1:0] EBIT_2ND_FR  = FRAME_W'(15);
  localparam logic [SMF_W-1:0]   CRC_LAST_OFS = SMF_W'(6);
  localparam logic [SMF_W-1:0]   SMF_END_OFS  = SMF_W'(7);

  localparam logic [MFAS_W-1:0]  MFAS_EXPECT  = 6'b001011;
  localparam logic [SA6_W-1:0]   SA6_FEBE_A   = 4'b0001;
  localparam logic [SA6_W-1:0]   SA6_CRC_A    = 4'b0010;
  localparam logic [SA6_W-1:0]   SA6_BOTH     = 4'b0011;

  typedef struct packed {
    logic mfas_err;
    logic crc_err;
    logic crc_exc;
    logic febe;
    logic nt_febe;
    logic nt_crc;
  } ev_t;
endpackage

// File: rtl/e1crc_field_capture.sv
module e1crc_field_capture
  import e1crc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_i,
  input  logic                valid_i,
  input  logic                bit1_i,
  input  logic                bit7_i,
  input  logic [FRAME_W-1:0]  frame_i,
  output logic                crc_done_o,
  output logic [CRC_W-1:0]    crc_word_o,
  output logic                smf_end_o,
  output logic [SA6_W-1:0]    sa6_word_o,
  output logic                mfas_done_o,
  output logic [MFAS_W-1:0]   mfas_word_o,
  output logic                ebit_done_o,
  output logic [EBIT_W-1:0]   ebit_word_o
);
  logic [SMF_W-1:0]  ofs;
  logic              take;
  logic              mf_seen_q, smf_seen_q;
  logic [CRC_W-2:0]  crc_sr_q;
  logic [SA6_W-2:0]  sa6_sr_q;
  logic [MFAS_W-2:0] mfas_sr_q;
  logic              ebit_first_q;

  assign ofs  = frame_i[SMF_W-1:0];
  assign take = sync_i & valid_i;

  // start-of-structure tracking: a word is judged only if seen from its start
  always_ff @(posedge clk) begin
    if (rst || !sync_i) begin
      mf_seen_q  <= 1'b0;
      smf_seen_q <= 1'b0;
    end else if (valid_i) begin
      if (frame_i == '0)   mf_seen_q  <= 1'b1;
      if (ofs == '0)       smf_seen_q <= 1'b1;
    end
  end

  // bit collectors
  always_ff @(posedge clk) begin
    if (rst) begin
      crc_sr_q     <= '0;
      sa6_sr_q     <= '0;
      mfas_sr_q    <= '0;
      ebit_first_q <= 1'b0;
    end else if (take) begin
      if (!frame_i[0] && ofs != SMF_END_OFS)
        crc_sr_q <= {crc_sr_q[CRC_W-3:0], bit1_i};
      if (frame_i[0])
        sa6_sr_q <= {sa6_sr_q[SA6_W-3:0], bit7_i};
      if (frame_i[0] && frame_i <= MFAS_LAST_FR)
        mfas_sr_q <= {mfas_sr_q[MFAS_W-3:0], bit1_i};
      if (frame_i == EBIT_1ST_FR)
        ebit_first_q <= bit1_i;
    end
  end

  assign crc_word_o  = {crc_sr_q, bit1_i};
  assign sa6_word_o  = {sa6_sr_q, bit7_i};
  assign mfas_word_o = {mfas_sr_q, bit1_i};
  assign ebit_word_o = {ebit_first_q, bit1_i};

  assign crc_done_o  = take & smf_seen_q & (ofs == CRC_LAST_OFS);
  assign smf_end_o   = take & smf_seen_q & (ofs == SMF_END_OFS);
  assign mfas_done_o = take & mf_seen_q  & (frame_i == MFAS_LAST_FR);
  assign ebit_done_o = take & smf_seen_q & (frame_i == EBIT_2ND_FR);

  // R8: nothing completes while out of sync
  assert_no_done_nosync_R8: assert property (@(posedge clk) disable iff (rst)
    !sync_i |-> !(crc_done_o || smf_end_o || mfas_done_o || ebit_done_o));
endmodule

// File: rtl/e1crc_crc_compare.sv
module e1crc_crc_compare
  import e1crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic             smf_end_i,
  input  logic [CRC_W-1:0] crc_local_i,
  input  logic             crc_done_i,
  input  logic [CRC_W-1:0] crc_word_i,
  output logic             crc_err_o
);
  logic [CRC_W-1:0] ref_q;
  logic             ref_ok_q;

  always_ff @(posedge clk) begin
    if (rst || !sync_i) begin
      ref_q    <= '0;
      ref_ok_q <= 1'b0;
    end else if (smf_end_i) begin
      ref_q    <= crc_local_i;
      ref_ok_q <= 1'b1;
    end
  end

  assign crc_err_o = crc_done_i & ref_ok_q & (crc_word_i != ref_q);

  // R2: a reference exists only after a sub-multiframe end was accepted
  assert_ref_after_end_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_ok_q) |-> $past(smf_end_i));
endmodule

// File: rtl/e1crc_err_window.sv
module e1crc_err_window #(
  parameter int THRESH = 915
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic tick_i,
  input  logic err_i,
  output logic exc_o
);
  localparam int CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (tick_i)                      cnt_d = err_i ? ONE : '0;
    else if (err_i && cnt_q < LIMIT) cnt_d = cnt_q + ONE;
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !sync_i) cnt_q <= '0;
    else                cnt_q <= cnt_d;
  end

  assign exc_o = sync_i & err_i & (cnt_d == LIMIT) & (tick_i | (cnt_q != LIMIT));

  // R3: count saturates at the threshold
  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  // R4: a tick leaves at most one error in the new window
  assert_tick_restart_R4: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> cnt_q <= ONE);
endmodule

// File: rtl/e1crc_mf_checker.sv
module e1crc_mf_checker
  import e1crc_pkg::*;
#(
  parameter int EXC_THRESH = 915
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ts0_valid_i,
  input  logic               ts0_bit1_i,
  input  logic               ts0_bit7_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CRC_W-1:0]   crc_local_i,
  input  logic               sec_tick_i,
  input  logic               mf_sync_i,
  output logic               mfas_err_o,
  output logic               crc_err_o,
  output logic               crc_exc_o,
  output logic               febe_o,
  output logic               nt_febe_o,
  output logic               nt_crc_o
);
  logic               crc_done, smf_end, mfas_done, ebit_done;
  logic [CRC_W-1:0]   crc_word;
  logic [SA6_W-1:0]   sa6_word;
  logic [MFAS_W-1:0]  mfas_word;
  logic [EBIT_W-1:0]  ebit_word;
  logic               crc_err, crc_exc;
  ev_t                ev_d, ev_q;

  e1crc_field_capture u_cap (
    .clk(clk), .rst(rst), .sync_i(mf_sync_i), .valid_i(ts0_valid_i),
    .bit1_i(ts0_bit1_i), .bit7_i(ts0_bit7_i), .frame_i(frame_i),
    .crc_done_o(crc_done), .crc_word_o(crc_word), .smf_end_o(smf_end),
    .sa6_word_o(sa6_word), .mfas_done_o(mfas_done), .mfas_word_o(mfas_word),
    .ebit_done_o(ebit_done), .ebit_word_o(ebit_word)
  );

  e1crc_crc_compare u_cmp (
    .clk(clk), .rst(rst), .sync_i(mf_sync_i), .smf_end_i(smf_end),
    .crc_local_i(crc_local_i), .crc_done_i(crc_done), .crc_word_i(crc_word),
    .crc_err_o(crc_err)
  );

  e1crc_err_window #(.THRESH(EXC_THRESH)) u_win (
    .clk(clk), .rst(rst), .sync_i(mf_sync_i), .tick_i(sec_tick_i),
    .err_i(crc_err), .exc_o(crc_exc)
  );

  always_comb begin
    ev_d          = '0;
    ev_d.mfas_err = mfas_done & (mfas_word != MFAS_EXPECT);
    ev_d.crc_err  = crc_err;
    ev_d.crc_exc  = crc_exc;
    ev_d.febe     = ebit_done & (ebit_word != {EBIT_W{1'b1}});
    ev_d.nt_febe  = smf_end & ((sa6_word == SA6_FEBE_A) | (sa6_word == SA6_BOTH));
    ev_d.nt_crc   = smf_end & ((sa6_word == SA6_CRC_A)  | (sa6_word == SA6_BOTH));
  end

  always_ff @(posedge clk) begin
    if (rst)            ev_q <= '0;
    else if (mf_sync_i) ev_q <= ev_d;
    else                ev_q <= '0;
  end

  assign mfas_err_o = ev_q.mfas_err;
  assign crc_err_o  = ev_q.crc_err;
  assign crc_exc_o  = ev_q.crc_exc;
  assign febe_o     = ev_q.febe;
  assign nt_febe_o  = ev_q.nt_febe;
  assign nt_crc_o   = ev_q.nt_crc;

  assert_quiet_nosync_R8: assert property (@(posedge clk) disable iff (rst)
    !mf_sync_i |=> !(mfas_err_o || crc_err_o || crc_exc_o || febe_o || nt_febe_o || nt_crc_o));
  assert_mfas_timing_R1: assert property (@(posedge clk) disable iff (rst)
    mfas_err_o |-> $past(ts0_valid_i && frame_i == MFAS_LAST_FR));
  assert_crc_timing_R2: assert property (@(posedge clk) disable iff (rst)
    crc_err_o |-> $past(ts0_valid_i && frame_i[SMF_W-1:0] == CRC_LAST_OFS));
  assert_exc_with_err_R3: assert property (@(posedge clk) disable iff (rst)
    crc_exc_o |-> crc_err_o);
  assert_febe_timing_R5: assert property (@(posedge clk) disable iff (rst)
    febe_o |-> $past(ts0_valid_i && frame_i == EBIT_2ND_FR));
  assert_nt_timing_R6: assert property (@(posedge clk) disable iff (rst)
    (nt_febe_o || nt_crc_o) |-> $past(ts0_valid_i && frame_i[SMF_W-1:0] == SMF_END_OFS));
  assert_nt_both_R7: assert property (@(posedge clk) disable iff (rst)
    (nt_febe_o && nt_crc_o) |-> $past(ts0_bit7_i));
endmodule

// File: tb/e1crc_mf_checker_tb.sv
module e1crc_mf_checker_tb_top;
  localparam int TH = 915;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ts0_valid = 1'b0, b1 = 1'b0, b7 = 1'b0, tick = 1'b0, sync = 1'b0;
  logic [3:0] frame = '0, crcl = '0;
  logic o_mfas, o_crc, o_exc, o_febe, o_ntf, o_ntc;

  always #2 clk = ~clk;

  e1crc_mf_checker #(.EXC_THRESH(TH)) dut_i (
    .clk(clk), .rst(rst), .ts0_valid_i(ts0_valid), .ts0_bit1_i(b1), .ts0_bit7_i(b7),
    .frame_i(frame), .crc_local_i(crcl), .sec_tick_i(tick), .mf_sync_i(sync),
    .mfas_err_o(o_mfas), .crc_err_o(o_crc), .crc_exc_o(o_exc), .febe_o(o_febe),
    .nt_febe_o(o_ntf), .nt_crc_o(o_ntc)
  );

  int n_tests = 0, n_fail = 0, n_exc = 0;
  bit done = 0;
  int wcnt = 0;
  int tick_frame = -1;
  logic [3:0] prev_l = '0;
  bit have_prev = 0;

  task automatic chk(input string req, input logic act, input logic exp, input int fr);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s frame %0d: actual %b expected %b", req, fr, act, exp);
    end
  endtask

  // one multiframe from frame `first`, checking every output after each frame
  task automatic run_mf(input logic [5:0] m, input logic [3:0] c0, input logic [3:0] c1,
                        input logic [3:0] l0, input logic [3:0] l1, input logic [1:0] e,
                        input logic [3:0] s0, input logic [3:0] s1, input bit sy, input int first);
    bit ok0 = (first == 0);
    bit ok1 = (first <= 8);
    for (int f = first; f < 16; f++) begin
      logic em = 0, ec = 0, ex = 0, ef = 0, enf = 0, enc = 0;
      int o = f % 8;
      logic [3:0] cw = (f < 8) ? c0 : c1;
      logic [3:0] sw = (f < 8) ? s0 : s1;
      bit tk = (f == tick_frame);
      ts0_valid = 1'b1; frame = 4'(f); sync = sy; tick = tk;
      crcl = (f == 7) ? l0 : (f == 15) ? l1 : ~l0;
      if (f % 2 == 0) begin b1 = cw[3 - o/2]; b7 = f[1]; end
      else begin
        b7 = sw[3 - (o-1)/2];
        if (f <= 11)      b1 = m[5 - (f-1)/2];
        else if (f == 13) b1 = e[1];
        else if (f == 15) b1 = e[0];
        else              b1 = f[2];
      end
      if (!sy) begin wcnt = 0; have_prev = 0; end
      else begin
        if (f == 11 && ok0) em = (m != 6'b001011);
        if (f == 6 && ok0 && have_prev) ec = (c0 != prev_l);
        if (f == 14 && ok1 && have_prev) ec = (c1 != prev_l);
        if (f == 7 && ok0)  begin prev_l = l0; have_prev = 1; end
        if (f == 15 && ok1) begin prev_l = l1; have_prev = 1; end
        if (tk) begin wcnt = ec ? 1 : 0; ex = ec && (TH == 1); end
        else if (ec && wcnt < TH) begin wcnt++; ex = (wcnt == TH); end
        if (f == 15 && ok1) ef = (e != 2'b11);
        if ((f == 7 && ok0) || (f == 15 && ok1)) begin
          enf = (sw == 4'b0001) || (sw == 4'b0011);
          enc = (sw == 4'b0010) || (sw == 4'b0011);
        end
      end
      @(posedge clk); @(negedge clk);
      if (ex) n_exc++;
      chk("R1 mfas",   o_mfas, em,  f);
      chk("R2 crc",    o_crc,  ec,  f);
      chk("R3/R4 exc", o_exc,  ex,  f);
      chk("R5 febe",   o_febe, ef,  f);
      chk("R6 ntfebe", o_ntf,  enf, f);
      chk("R7 ntcrc",  o_ntc,  enc, f);
      if (!sy) chk("R8 quiet", o_mfas|o_crc|o_exc|o_febe|o_ntf|o_ntc, 1'b0, f);
    end
    ts0_valid = 1'b0; tick = 1'b0;
  endtask

  task automatic idle(input int n);
    ts0_valid = 1'b0; b1 = 1'b0; b7 = 1'b1; frame = 4'd11;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 idle", o_mfas|o_crc|o_exc|o_febe|o_ntf|o_ntc, 1'b0, -1);
    end
  endtask

  task automatic good_mf();
    run_mf(6'b001011, 4'h9, 4'h9, 4'h9, 4'h9, 2'b11, 4'h0, 4'h8, 1'b1, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", o_mfas|o_crc|o_exc|o_febe|o_ntf|o_ntc, 1'b0, -1);
    rst = 1'b0;
    good_mf(); good_mf();
    // R1: all alignment words
    for (int p = 0; p < 64; p++)
      run_mf(6'(p), 4'h9, 4'h9, 4'h9, 4'h9, 2'b11, 4'h0, 4'h0, 1'b1, 0);
    // R2: every (stored, received) pair at the second sub-multiframe
    for (int i = 0; i < 256; i++)
      run_mf(6'b001011, 4'h0, 4'(i / 16), 4'(i % 16), 4'h0, 2'b11, 4'h0, 4'h0, 1'b1, 0);
    // R5: E bit pairs
    for (int e = 0; e < 4; e++)
      run_mf(6'b001011, 4'h0, 4'h0, 4'h0, 4'h0, 2'(e), 4'h0, 4'h0, 1'b1, 0);
    // R6, R7: all Sa6 codewords, with idle gaps (R9)
    for (int s = 0; s < 16; s++) begin
      run_mf(6'b001011, 4'h0, 4'h0, 4'h0, 4'h0, 2'b11, 4'(s), 4'(15 - s), 1'b1, 0);
      idle(2);
    end
    // R8: corrupt data out of sync, then mid-multiframe resync
    run_mf(6'b111111, 4'h5, 4'h6, 4'h1, 4'h2, 2'b00, 4'h3, 4'h3, 1'b0, 0);
    run_mf(6'b111111, 4'h5, 4'h6, 4'h1, 4'h2, 2'b00, 4'h3, 4'h3, 1'b1, 5);
    run_mf(6'b111111, 4'h5, 4'h6, 4'h1, 4'h2, 2'b00, 4'h3, 4'h3, 1'b0, 0);
    run_mf(6'b111111, 4'h5, 4'h6, 4'h1, 4'h2, 2'b00, 4'h3, 4'h3, 1'b1, 10);
    good_mf();
    // R3: window reaches the threshold exactly once
    tick_frame = 0; good_mf(); tick_frame = -1;
    n_exc = 0;
    for (int k = 0; k < 457; k++)
      run_mf(6'b001011, 4'hC, 4'hC, 4'h3, 4'h3, 2'b11, 4'h0, 4'h0, 1'b1, 0);
    chk("R3 no exc at 914", n_exc != 0, 1'b0, -1);
    run_mf(6'b001011, 4'hC, 4'hC, 4'h3, 4'h3, 2'b11, 4'h0, 4'h0, 1'b1, 0);
    chk("R3 one exc at 915", n_exc == 1, 1'b1, -1);
    // R4: tick on the same cycle as an error
    tick_frame = 6;
    run_mf(6'b001011, 4'hC, 4'hC, 4'h3, 4'h3, 2'b11, 4'h0, 4'h0, 1'b1, 0);
    tick_frame = -1; n_exc = 0;
    for (int k = 0; k < 457; k++)
      run_mf(6'b001011, 4'hC, 4'hC, 4'h3, 4'h3, 2'b11, 4'h0, 4'h0, 1'b1, 0);
    chk("R4 exc in new window", n_exc == 1, 1'b1, -1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule